// File: doc/BRIEF.md
# Priority-Ordered Peripheral Pin Crossbar

This block hands a bank of general-purpose pins to a set of on-chip digital peripherals. The peripherals are an asynchronous serial port, a two-wire bus, an array of capture/compare output channels and two external interrupt inputs. The pins are not fixed. Each enabled signal takes the next free pin in a fixed order of precedence. Any pin marked as an analog input is passed over. As a result, a signal moves to a different pin when a peripheral with higher precedence is switched on or when a pin is reserved for analog use.

Allocation is purely combinational from the configuration inputs. Pins that no signal claims, and every pin while the crossbar is off, behave as plain I/O driven from their port latch bits. Each pin has an output-mode bit that selects push-pull or open-drain drive. Peripheral inputs read the pin they were given, or a constant 1 when they have none. When the enabled signals need more pins than there are digital pins, a flag reports it.

Top module: `pin_crossbar`

## Requirements
- R1: When the crossbar is on, enabled signals take consecutive digital pins in this order: serial transmit, serial receive, two-wire data, two-wire clock, capture/compare channels 0 upward, interrupt 0, interrupt 1. Pin 0 is filled first.
- R2: `ccu_code` sets how many capture/compare channels are allocated. Code 0 allocates none, code n allocates n channels, and codes above MAXCH (default 6) allocate MAXCH channels.
- R3: A pin with `pin_digital` = 0 gets no signal and is skipped, so the next signal goes to the following digital pin. The pin is driven as plain I/O from its latch bit.
- R4: While `xbar_en` = 0, no pin is allocated: all pins are plain I/O, every peripheral input reads 1, and `overflow` is 0.
- R5: Drive of an output-capable pin with value v: when `pin_pushpull` = 1, `pin_oe` = 1 and `pin_out` = v; when it is 0 (open-drain), `pin_out` = 0 and `pin_oe` = ~v, so a 1 leaves the pin in high impedance.
- R6: A digital pin left over after the last allocated signal is plain I/O, with v taken from its `port_latch` bit.
- R7: A pin given to serial receive or to an interrupt has `pin_oe` = 0 and `pin_out` = 0. Serial receive, the interrupts, and two-wire data and clock read the `pin_in` bit of their assigned pin.
- R8: A peripheral input signal that has no pin reads 1.
- R9: `overflow` is 1 exactly when the crossbar is on and the enabled signals outnumber the digital pins. The signals that do not fit get no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xbar_en | input | 1 | Global crossbar enable |
| uart_en | input | 1 | Serial port enable (transmit and receive) |
| twi_en | input | 1 | Two-wire bus enable (data and clock) |
| ccu_code | input | 3 | Capture/compare channel count code |
| int0_en | input | 1 | Interrupt 0 input enable |
| int1_en | input | 1 | Interrupt 1 input enable |
| pin_digital | input | NPINS | Per pin: 1 digital, 0 analog input |
| pin_pushpull | input | NPINS | Per pin: 1 push-pull, 0 open-drain |
| port_latch | input | NPINS | Port latch value per pin |
| pin_in | input | NPINS | Sensed pin levels |
| uart_tx | input | 1 | Serial transmit value from the peripheral |
| twi_sda_out | input | 1 | Two-wire data drive value |
| twi_scl_out | input | 1 | Two-wire clock drive value |
| ccu_out | input | MAXCH | Capture/compare channel outputs |
| pin_out | output | NPINS | Pin drive value |
| pin_oe | output | NPINS | Pin output enable |
| uart_rx | output | 1 | Serial receive as read from its pin |
| twi_sda_in | output | 1 | Two-wire data as read from its pin |
| twi_scl_in | output | 1 | Two-wire clock as read from its pin |
| int0_in | output | 1 | Interrupt 0 line as read from its pin |
| int1_in | output | 1 | Interrupt 1 line as read from its pin |
| overflow | output | 1 | More enabled signals than digital pins |

## Verification
The block has no stored state. A wrong rank count or a wrong skip decision is visible at once, in the same evaluation, as a signal on the wrong pin. Because the allocation packs signals, every lower-precedence signal after the fault lands one pin off, so checking single pins at known positions exposes the fault. A mode fault shows as an open-drain pin that drives high, or as an analog pin that does not follow its latch. Directed patterns cover the full layout, a shifted layout, clamped channel codes and the case where the signals do not fit.

// File: rtl/pin_crossbar.sv
module pin_crossbar #(
  parameter int NPINS = 16,
  parameter int MAXCH = 6
) (
  input  logic             xbar_en,
  input  logic             uart_en,
  input  logic             twi_en,
  input  logic [2:0]       ccu_code,
  input  logic             int0_en,
  input  logic             int1_en,
  input  logic [NPINS-1:0] pin_digital,
  input  logic [NPINS-1:0] pin_pushpull,
  input  logic [NPINS-1:0] port_latch,
  input  logic [NPINS-1:0] pin_in,
  input  logic             uart_tx,
  input  logic             twi_sda_out,
  input  logic             twi_scl_out,
  input  logic [MAXCH-1:0] ccu_out,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             uart_rx,
  output logic             twi_sda_in,
  output logic             twi_scl_in,
  output logic             int0_in,
  output logic             int1_in,
  output logic             overflow
);
  localparam int NSIG = MAXCH + 6;
  localparam int S_RX = 1, S_SDA = 2, S_SCL = 3, S_INT0 = NSIG - 2, S_INT1 = NSIG - 1;

  logic [NSIG-1:0] sig_en, sig_val, sig_isin, sig_has, sig_rd;
  int              sig_rank [NSIG];
  int              sig_pin  [NSIG];
  int              pin_rank [NPINS];
  int              nch, n_en, n_dig;

  always_comb begin
    nch = (int'(ccu_code) > MAXCH) ? MAXCH : int'(ccu_code);
    sig_en   = '0;
    sig_val  = '0;
    sig_isin = '0;
    sig_en[0] = uart_en;  sig_val[0] = uart_tx;
    sig_en[S_RX] = uart_en;  sig_isin[S_RX] = 1'b1;
    sig_en[S_SDA] = twi_en;  sig_val[S_SDA] = twi_sda_out;
    sig_en[S_SCL] = twi_en;  sig_val[S_SCL] = twi_scl_out;
    for (int c = 0; c < MAXCH; c++) begin
      sig_en[4+c]  = (c < nch);
      sig_val[4+c] = ccu_out[c];
    end
    sig_en[S_INT0] = int0_en;  sig_isin[S_INT0] = 1'b1;
    sig_en[S_INT1] = int1_en;  sig_isin[S_INT1] = 1'b1;

    n_en = 0;
    for (int s = 0; s < NSIG; s++) begin
      sig_rank[s] = n_en;
      if (sig_en[s]) n_en++;
    end
    n_dig = 0;
    for (int p = 0; p < NPINS; p++) begin
      pin_rank[p] = n_dig;
      if (pin_digital[p]) n_dig++;
    end
    overflow = xbar_en && (n_en > n_dig);

    sig_has = '0;
    for (int s = 0; s < NSIG; s++) sig_pin[s] = 0;
    for (int p = 0; p < NPINS; p++) begin
      logic hit, isin, v;
      hit  = 1'b0;
      isin = 1'b0;
      v    = port_latch[p];
      for (int s = 0; s < NSIG; s++)
        if (xbar_en && pin_digital[p] && sig_en[s] && sig_rank[s] == pin_rank[p]) begin
          hit = 1'b1;
          isin = sig_isin[s];
          v = sig_val[s];
          sig_has[s] = 1'b1;
          sig_pin[s] = p;
        end
      if (hit && isin) begin
        pin_out[p] = 1'b0;
        pin_oe[p]  = 1'b0;
      end else if (pin_pushpull[p]) begin
        pin_out[p] = v;
        pin_oe[p]  = 1'b1;
      end else begin
        pin_out[p] = 1'b0;
        pin_oe[p]  = ~v;
      end
    end

    for (int s = 0; s < NSIG; s++)
      sig_rd[s] = sig_has[s] ? pin_in[sig_pin[s]] : 1'b1;
  end

  assign uart_rx    = sig_rd[S_RX];
  assign twi_sda_in = sig_rd[S_SDA];
  assign twi_scl_in = sig_rd[S_SCL];
  assign int0_in    = sig_rd[S_INT0];
  assign int1_in    = sig_rd[S_INT1];
endmodule

module pin_crossbar_chk #(
  parameter int NPINS = 16,
  parameter int MAXCH = 6
) (
  input logic             xbar_en,
  input logic             uart_en,
  input logic             uart_tx,
  input logic [NPINS-1:0] pin_digital,
  input logic [NPINS-1:0] pin_pushpull,
  input logic [NPINS-1:0] port_latch,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic             uart_rx,
  input logic             twi_sda_in,
  input logic             twi_scl_in,
  input logic             int0_in,
  input logic             int1_in,
  input logic             overflow
);
  always_comb begin
    if (!xbar_en)
      assert_off_inputs_idle_R4: assert (uart_rx && twi_sda_in && twi_scl_in && int0_in && int1_in && !overflow);
    assert_flag_needs_enable_R9: assert (!overflow || xbar_en);
    if (xbar_en && uart_en && pin_digital[0] && pin_pushpull[0])
      assert_tx_first_pin_R1: assert (pin_oe[0] && pin_out[0] == uart_tx);
    for (int p = 0; p < NPINS; p++) begin
      if (!pin_pushpull[p] && pin_oe[p])
        assert_od_never_high_R5: assert (pin_out[p] == 1'b0);
      if (!pin_digital[p])
        assert_analog_is_gpio_R3: assert (pin_pushpull[p] ? (pin_oe[p] && pin_out[p] == port_latch[p])
                                                          : (!pin_out[p] && pin_oe[p] == !port_latch[p]));
    end
  end
endmodule

bind pin_crossbar pin_crossbar_chk #(.NPINS(NPINS), .MAXCH(MAXCH)) u_chk (
  .xbar_en(xbar_en), .uart_en(uart_en), .uart_tx(uart_tx), .pin_digital(pin_digital),
  .pin_pushpull(pin_pushpull), .port_latch(port_latch), .pin_out(pin_out), .pin_oe(pin_oe),
  .uart_rx(uart_rx), .twi_sda_in(twi_sda_in), .twi_scl_in(twi_scl_in),
  .int0_in(int0_in), .int1_in(int1_in), .overflow(overflow)
);

// File: tb/test_pin_crossbar.sv
`timescale 1ns/1ps
module test_pin_crossbar;
  localparam int NP = 16;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic xbar_en, uart_en, twi_en, int0_en, int1_en;
  logic [2:0] ccu_code;
  logic [NP-1:0] pin_digital, pin_pushpull, port_latch, pin_in, pin_out, pin_oe;
  logic uart_tx, twi_sda_out, twi_scl_out;
  logic [5:0] ccu_out;
  logic uart_rx, twi_sda_in, twi_scl_in, int0_in, int1_in, overflow;
  int checks = 0, errors = 0;
  bit done = 0;

  pin_crossbar i_pin_crossbar (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_pin(string tag, int p, logic eo, logic eoe);
    chk($sformatf("%s pin%0d", tag, p), {30'd0, pin_out[p], pin_oe[p]}, {30'd0, eo, eoe});
  endtask

  task automatic base();
    xbar_en = 1; uart_en = 1; twi_en = 1; ccu_code = 3'd6; int0_en = 1; int1_en = 1;
    pin_digital = '1; pin_pushpull = '1; port_latch = '1; pin_in = '0;
    uart_tx = 0; twi_sda_out = 1; twi_scl_out = 0; ccu_out = 6'b101010;
  endtask

  task automatic t_off();
    base(); xbar_en = 0; port_latch = 16'h00F0;
    #1;
    chk("R4 pins follow latch", {16'd0, pin_out}, 32'h00F0);
    chk("R4 all driven", {16'd0, pin_oe}, 32'hFFFF);
    chk("R4 R8 inputs read 1", {27'd0, uart_rx, twi_sda_in, twi_scl_in, int0_in, int1_in}, 32'h1F);
    chk("R4 no flag", {31'd0, overflow}, 0);
  endtask

  task automatic t_full();
    base(); pin_digital = 16'hE3FF; port_latch = 16'hA400;
    pin_in = 16'b0100_0000_0000_1000;
    #1;
    chk_pin("R1 tx", 0, 0, 1);
    chk_pin("R7 rx", 1, 0, 0);
    chk_pin("R1 sda", 2, 1, 1);
    chk_pin("R1 scl", 3, 0, 1);
    for (int c = 0; c < 6; c++) chk_pin("R1 R2 cex", 4 + c, ccu_out[c], 1);
    chk_pin("R3 analog latch1", 10, 1, 1);
    chk_pin("R3 analog latch0", 11, 0, 1);
    chk_pin("R3 R7 int0 after skip", 13, 0, 0);
    chk_pin("R7 int1", 14, 0, 0);
    chk_pin("R6 spare", 15, 1, 1);
    chk("R7 readback", {27'd0, uart_rx, twi_sda_in, twi_scl_in, int0_in, int1_in}, 32'b00101);
    chk("R9 fits", {31'd0, overflow}, 0);
  endtask

  task automatic t_shift();
    base(); uart_en = 0; ccu_code = 3'd2; int1_en = 0; port_latch = 16'h0000;
    #1;
    chk_pin("R1 sda moves", 0, 1, 1);
    chk_pin("R1 scl moves", 1, 0, 1);
    chk_pin("R2 cex0", 2, 0, 1);
    chk_pin("R2 cex1", 3, 1, 1);
    chk_pin("R1 int0 moves", 4, 0, 0);
    chk_pin("R6 spare", 5, 0, 1);
    chk("R8 unassigned read 1", {30'd0, uart_rx, int1_in}, 3);
  endtask

  task automatic t_codes();
    base(); uart_en = 0; twi_en = 0; int0_en = 0; int1_en = 0; ccu_code = 3'd7; ccu_out = 6'b111111;
    port_latch = 16'h0000;
    #1;
    chk_pin("R2 code7 ch5", 5, 1, 1);
    chk_pin("R2 code7 clamps", 6, 0, 1);
    ccu_code = 3'd0; int1_en = 1; pin_in = 16'h0001;
    #1;
    chk_pin("R2 code0 int1 first", 0, 0, 0);
    chk("R7 int1 reads pin0", {31'd0, int1_in}, 1);
  endtask

  task automatic t_opendrain();
    base(); pin_digital = 16'hE3FF; pin_pushpull = '0; port_latch = 16'hA400;
    #1;
    chk_pin("R5 od tx0", 0, 0, 1);
    chk_pin("R5 od sda1", 2, 0, 0);
    chk_pin("R5 od analog latch1", 10, 0, 0);
    chk_pin("R5 od analog latch0", 11, 0, 1);
  endtask

  task automatic t_overflow();
    base(); pin_digital = 16'h003F; port_latch = 16'h0000;
    #1;
    chk("R9 flag", {31'd0, overflow}, 1);
    chk_pin("R9 last fit cex1", 5, ccu_out[1], 1);
    chk("R9 R8 int0 no pin", {31'd0, int0_in}, 1);
    pin_digital = 16'h0FFF;
    #1;
    chk("R9 exact fit", {31'd0, overflow}, 0);
    chk_pin("R9 int1 last", 11, 0, 0);
  endtask

  initial begin
    t_off(); t_full(); t_shift(); t_codes(); t_opendrain(); t_overflow();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule